// File: doc/BRIEF.md
# Rank-Based Ready Instruction Selector

This block chooses, once per clock, a single instruction to issue from a vector of ready slots. Each slot presents its position in program order (the source index), the number of known consumers of its result, and a mask of the pipeline resource units it needs. A mask of the units that are free this cycle arrives as a separate input. Among the slots that are ready and whose units are all free, the block grants the one with the lowest rank. The rank is the source index minus the consumer count, so an instruction that many others wait on moves ahead of older ones with few consumers.

Alongside the grant, the block reports resource pressure. Each ready slot that cannot issue because one of its units is taken is flagged in a blocked-slot vector. The units it lacked are ORed into a busy-resource mask, which is rebuilt from scratch every cycle and never carried over. The block also gives the identifier of the most significant busy unit. Storing the slots and waking them up are handled by the surrounding scheduler. All outputs are registered and describe the inputs sampled at the previous rising clock edge.

Top module: `rank_issue_select`

## Requirements
- R1: The rank of a slot is its source index minus its consumer count, computed as a signed value. Among eligible slots, the grant goes to the slot with the lowest rank, even when that slot has the larger source index.
- R2: When eligible slots have equal rank, the one with the smaller source index wins. If the source indices are also equal, the lower slot number wins.
- R3: A slot is eligible when its ready bit is 1 and (required mask AND NOT free mask) is zero. A ready slot with an all-zero required mask is therefore eligible even when no unit is free.
- R4: `grant_valid_o` is 1 exactly when at least one slot is eligible. When it is 0, `grant_slot_o` is 0.
- R5: `busy_mask_o` is the OR, over all ready slots, of (required mask AND NOT free mask). It is recomputed every cycle from the current inputs, with no bits held from earlier cycles.
- R6: Bit i of `blocked_o` is 1 exactly when slot i is ready and at least one of its required units is not free. A granted slot is never marked blocked.
- R7: `busy_top_o` holds the bit position of the most significant set bit of `busy_mask_o`, and 0 when that mask is zero.
- R8: Every output changes only at a rising clock edge and reflects the inputs sampled at that edge. The active-low reset sets all outputs to 0.
- R9: A slot whose ready bit is 0 is never granted and adds nothing to `busy_mask_o` or `blocked_o`, whatever its index, consumer count or resource fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ready_i | input | ENTRIES | Ready bit per slot |
| src_idx_i | input | ENTRIES*IDX_W | Source-order index per slot; slot i occupies bits [i*IDX_W +: IDX_W] |
| users_i | input | ENTRIES*USR_W | Known consumer count per slot; slot i occupies bits [i*USR_W +: USR_W] |
| req_mask_i | input | ENTRIES*RES_W | Required resource units per slot; slot i occupies bits [i*RES_W +: RES_W] |
| res_free_i | input | RES_W | Resource units that are free this cycle |
| grant_valid_o | output | 1 | A slot was granted |
| grant_slot_o | output | $clog2(ENTRIES) | Number of the granted slot |
| busy_mask_o | output | RES_W | Units that blocked ready slots |
| blocked_o | output | ENTRIES | Ready slots held back by busy units |
| busy_top_o | output | $clog2(RES_W) | Position of the highest set bit of the busy mask |

## Verification
Every result is registered once, so each one is due at the rising edge after the inputs are applied, which is exactly one cycle later. The bench changes the inputs at a falling edge. It checks one time unit later that the outputs still show the previous vector's results, then compares all outputs with the new expectation at the next falling edge. It sweeps a four-slot, eight-unit configuration with thousands of vectors in which ranks often tie. It also runs directed vectors for zero-requirement slots, non-ready slots with the best rank, mixed resource pressure and the clearing of the busy mask on the following cycle.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

   localparam int MAX_RES_UNITS = 64;

   // Position of the highest set bit of a unit mask; 0 for an empty mask.
   function automatic logic [5:0] top_unit(input logic [MAX_RES_UNITS-1:0] m);
      logic [5:0] pos;
      pos = '0;
      for (int b = 0; b < MAX_RES_UNITS; b++) begin
         if (m[b]) pos = 6'(b);
      end
      return pos;
   endfunction

endpackage

// File: rtl/rsel_entry.sv
module rsel_entry #(
   parameter int IDX_W = 6,
   parameter int USR_W = 3,
   parameter int RES_W = 64,
   parameter int RK_W  = 7
) (
   input  logic                    ready_i,
   input  logic [IDX_W-1:0]        src_i,
   input  logic [USR_W-1:0]        users_i,
   input  logic [RES_W-1:0]        req_i,
   input  logic [RES_W-1:0]        free_i,
   output logic                    elig_o,
   output logic                    blocked_o,
   output logic [RES_W-1:0]        missing_o,
   output logic signed [RK_W-1:0]  rank_o
);

   if (RK_W <= IDX_W || RK_W <= USR_W) begin : g_bad_rank_w
      $error("rsel_entry: rank width too narrow");
   end

   logic [RES_W-1:0] lack;

   assign lack      = req_i & ~free_i;
   assign elig_o    = ready_i && (lack == '0);
   assign blocked_o = ready_i && (lack != '0);
   assign missing_o = ready_i ? lack : '0;

   // Zero-extended operands keep the difference exact in signed form.
   assign rank_o = $signed({{(RK_W-IDX_W){1'b0}}, src_i})
                 - $signed({{(RK_W-USR_W){1'b0}}, users_i});

endmodule

// File: rtl/rsel_tree.sv
module rsel_tree #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 6,
   parameter int RK_W    = 7,
   parameter int EW      = 3
) (
   input  logic [ENTRIES-1:0]      elig_i,
   input  logic [ENTRIES*RK_W-1:0] rank_i,
   input  logic [ENTRIES*IDX_W-1:0] src_i,
   output logic                    win_valid_o,
   output logic [EW-1:0]           win_slot_o
);

   localparam int LV = $clog2(ENTRIES);
   localparam int P  = 1 << LV;

   // Heap layout: node 1 is the root, leaves sit at P .. 2P-1.
   logic                    nv  [1:2*P-1];
   logic signed [RK_W-1:0]  nrk [1:2*P-1];
   logic [IDX_W-1:0]        nsx [1:2*P-1];
   logic [EW-1:0]           nsl [1:2*P-1];

   for (genvar i = 0; i < P; i++) begin : g_leaf
      if (i < ENTRIES) begin : g_real
         assign nv[P+i]  = elig_i[i];
         assign nrk[P+i] = $signed(rank_i[i*RK_W +: RK_W]);
         assign nsx[P+i] = src_i[i*IDX_W +: IDX_W];
         assign nsl[P+i] = EW'(i);
      end else begin : g_pad
         assign nv[P+i]  = 1'b0;
         assign nrk[P+i] = '0;
         assign nsx[P+i] = '0;
         assign nsl[P+i] = '0;
      end
   end

   for (genvar n = 1; n < P; n++) begin : g_node
      logic take_hi;
      // The lower half wins unless the upper half is strictly better.
      assign take_hi = nv[2*n+1] &&
                       (!nv[2*n] ||
                        (nrk[2*n+1] < nrk[2*n]) ||
                        ((nrk[2*n+1] == nrk[2*n]) && (nsx[2*n+1] < nsx[2*n])));
      assign nv[n]  = nv[2*n] | nv[2*n+1];
      assign nrk[n] = take_hi ? nrk[2*n+1] : nrk[2*n];
      assign nsx[n] = take_hi ? nsx[2*n+1] : nsx[2*n];
      assign nsl[n] = take_hi ? nsl[2*n+1] : nsl[2*n];
   end

   assign win_valid_o = nv[1];
   assign win_slot_o  = nv[1] ? nsl[1] : '0;

endmodule

// File: rtl/rank_issue_select.sv
module rank_issue_select
   import rsel_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 6,
   parameter int USR_W   = 3,
   parameter int RES_W   = 64,
   localparam int EW     = $clog2(ENTRIES),
   localparam int IDW    = $clog2(RES_W)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ENTRIES-1:0]        ready_i,
   input  logic [ENTRIES*IDX_W-1:0]  src_idx_i,
   input  logic [ENTRIES*USR_W-1:0]  users_i,
   input  logic [ENTRIES*RES_W-1:0]  req_mask_i,
   input  logic [RES_W-1:0]          res_free_i,
   output logic                      grant_valid_o,
   output logic [EW-1:0]             grant_slot_o,
   output logic [RES_W-1:0]          busy_mask_o,
   output logic [ENTRIES-1:0]        blocked_o,
   output logic [IDW-1:0]            busy_top_o
);

   localparam int RK_W = ((IDX_W > USR_W) ? IDX_W : USR_W) + 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("rank_issue_select: ENTRIES must be at least 2");
   end
   if (RES_W < 2 || RES_W > MAX_RES_UNITS) begin : g_bad_res
      $error("rank_issue_select: RES_W must lie in 2..64");
   end
   if (IDX_W < 1 || USR_W < 1) begin : g_bad_fields
      $error("rank_issue_select: field widths must be positive");
   end

   logic [ENTRIES-1:0]       elig;
   logic [ENTRIES-1:0]       blk;
   logic [RES_W-1:0]         miss [ENTRIES];
   logic [ENTRIES*RK_W-1:0]  rank_flat;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      logic signed [RK_W-1:0] rk;
      rsel_entry #(
         .IDX_W(IDX_W), .USR_W(USR_W), .RES_W(RES_W), .RK_W(RK_W)
      ) u_entry (
         .ready_i  (ready_i[i]),
         .src_i    (src_idx_i[i*IDX_W +: IDX_W]),
         .users_i  (users_i[i*USR_W +: USR_W]),
         .req_i    (req_mask_i[i*RES_W +: RES_W]),
         .free_i   (res_free_i),
         .elig_o   (elig[i]),
         .blocked_o(blk[i]),
         .missing_o(miss[i]),
         .rank_o   (rk)
      );
      assign rank_flat[i*RK_W +: RK_W] = rk;
   end

   logic          win_valid;
   logic [EW-1:0] win_slot;

   rsel_tree #(
      .ENTRIES(ENTRIES), .IDX_W(IDX_W), .RK_W(RK_W), .EW(EW)
   ) u_tree (
      .elig_i     (elig),
      .rank_i     (rank_flat),
      .src_i      (src_idx_i),
      .win_valid_o(win_valid),
      .win_slot_o (win_slot)
   );

   logic [RES_W-1:0] busy_d;
   logic [5:0]       top_full;

   always_comb begin
      busy_d = '0;
      for (int i = 0; i < ENTRIES; i++) busy_d = busy_d | miss[i];
   end

   assign top_full = top_unit(MAX_RES_UNITS'(busy_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_valid_o <= 1'b0;
         grant_slot_o  <= '0;
         busy_mask_o   <= '0;
         blocked_o     <= '0;
         busy_top_o    <= '0;
      end else begin
         grant_valid_o <= win_valid;
         grant_slot_o  <= win_slot;
         busy_mask_o   <= busy_d;
         blocked_o     <= blk;
         busy_top_o    <= top_full[IDW-1:0];
      end
   end

   // The tree winner must be a ready slot (R9).
   assert_grant_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> ready_i[win_slot]);

   // A grant exists exactly when some slot is eligible (R4).
   assert_grant_iff_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid == (elig != '0));

   // The granted slot is never reported as blocked (R6).
   assert_grant_not_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid_o |-> !blocked_o[grant_slot_o]);

   // Blocked slots were ready at the capturing edge (R6).
   assert_blocked_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked_o & ~$past(ready_i)) == '0);

   // Pressure is reported on both outputs or on neither (R5).
   assert_busy_matches_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_mask_o != '0) == (blocked_o != '0));

   // The reported unit is the top set bit of the busy mask (R7).
   assert_busy_top_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_mask_o != '0) |-> ((busy_mask_o >> busy_top_o) == RES_W'(1)));

endmodule

// File: tb/rank_issue_select_test.sv
module rank_issue_select_test;

   localparam int N   = 4;
   localparam int IW  = 4;
   localparam int UW  = 2;
   localparam int RW  = 8;
   localparam int EW  = 2;
   localparam int IDW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    ready = '0;
   logic [N*IW-1:0] src = '0;
   logic [N*UW-1:0] users = '0;
   logic [N*RW-1:0] req = '0;
   logic [RW-1:0]   free = '0;
   logic            gv;
   logic [EW-1:0]   gs;
   logic [RW-1:0]   busy;
   logic [N-1:0]    blk;
   logic [IDW-1:0]  top;

   int checks = 0;
   int errors = 0;

   // Expectations for the vector in flight and for the one before it.
   int e_gv, e_gs, e_busy, e_blk, e_top, e_tie;
   int p_gv = 0, p_gs = 0, p_busy = 0, p_blk = 0, p_top = 0;

   always #2.5 clk = ~clk;

   rank_issue_select #(.ENTRIES(N), .IDX_W(IW), .USR_W(UW), .RES_W(RW)) uut (
      .clk(clk), .rst_n(rst_n), .ready_i(ready), .src_idx_i(src),
      .users_i(users), .req_mask_i(req), .res_free_i(free),
      .grant_valid_o(gv), .grant_slot_o(gs), .busy_mask_o(busy),
      .blocked_o(blk), .busy_top_o(top)
   );

   task automatic chk(input string req_tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req_tag, what, act, exp);
      end
   endtask

   task automatic model();
      int best_rank, best_src;
      int lack;
      e_gv = 0; e_gs = 0; e_busy = 0; e_blk = 0; e_top = 0; e_tie = 0;
      best_rank = 0; best_src = 0;
      for (int i = 0; i < N; i++) begin
         int s, u, r;
         s = int'(src[i*IW +: IW]);
         u = int'(users[i*UW +: UW]);
         r = s - u;
         lack = int'(req[i*RW +: RW] & ~free);
         if (ready[i]) begin
            if (lack != 0) begin
               e_blk  |= (1 << i);
               e_busy |= lack;
            end else if (e_gv == 0 || r < best_rank || (r == best_rank && s < best_src)) begin
               if (e_gv != 0 && r == best_rank) e_tie = 1;
               e_gv = 1; e_gs = i; best_rank = r; best_src = s;
            end else if (r == best_rank) begin
               e_tie = 1;
            end
         end
      end
      for (int b = 0; b < RW; b++) if (e_busy[b]) e_top = b;
   endtask

   // Called at a falling edge with the inputs already set.
   task automatic apply(input string gtag);
      string t;
      model();
      #1;
      chk("R8", "grant_valid held before edge", int'(gv), p_gv);
      chk("R8", "busy held before edge", int'(busy), p_busy);
      @(negedge clk);
      t = (gtag != "") ? gtag : (e_tie != 0 ? "R2" : "R1");
      chk("R4", "grant_valid", int'(gv), e_gv);
      chk(t, "grant_slot", int'(gs), e_gs);
      chk("R5", "busy_mask", int'(busy), e_busy);
      chk("R6", "blocked", int'(blk), e_blk);
      chk("R7", "busy_top", int'(top), e_top);
      p_gv = e_gv; p_gs = e_gs; p_busy = e_busy; p_blk = e_blk; p_top = e_top;
   endtask

   task automatic set_slot(input int i, input int s, input int u, input int rq);
      src[i*IW +: IW]   = IW'(s);
      users[i*UW +: UW] = UW'(u);
      req[i*RW +: RW]   = RW'(rq);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R8", "reset grant_valid", int'(gv), 0);
      chk("R8", "reset grant_slot", int'(gs), 0);
      chk("R8", "reset busy", int'(busy), 0);
      chk("R8", "reset blocked", int'(blk), 0);
      chk("R8", "reset top", int'(top), 0);
      rst_n = 1'b1;

      // R9: nothing ready, inputs otherwise loaded with pressure.
      for (int i = 0; i < N; i++) set_slot(i, i, 3, 8'hff);
      free = 8'h00; ready = 4'b0000;
      apply("R9");

      // R3: slot 2 needs no unit and issues with no unit free.
      set_slot(0, 1, 0, 8'h01); set_slot(1, 2, 0, 8'h40);
      set_slot(2, 9, 0, 8'h00); set_slot(3, 3, 0, 8'h10);
      ready = 4'b1111; free = 8'h00;
      apply("R3");

      // R9: best-ranked slot 0 not ready, its lacking units stay out of busy.
      set_slot(0, 0, 3, 8'h80); set_slot(1, 5, 0, 8'h01);
      set_slot(2, 6, 0, 8'h00); set_slot(3, 7, 0, 8'h02);
      ready = 4'b0110; free = 8'h01;
      apply("R9");

      // R1: younger slot 1 (15-3=12) beats older slot 2 (13-0=13).
      set_slot(0, 14, 0, 0); set_slot(1, 15, 3, 0);
      set_slot(2, 13, 0, 0); set_slot(3, 14, 1, 0);
      ready = 4'b0111; free = 8'hff;
      apply("R1");

      // R2: slots 0 (5-1) and 3 (4-0) tie; smaller index 4 wins -> slot 3.
      set_slot(0, 5, 1, 0); set_slot(1, 9, 0, 0);
      set_slot(2, 8, 0, 0); set_slot(3, 4, 0, 0);
      ready = 4'b1111;
      apply("R2");

      // R2: identical rank and index; lower slot number wins -> slot 1.
      set_slot(0, 9, 0, 0); set_slot(1, 6, 2, 0);
      set_slot(2, 6, 2, 0); set_slot(3, 7, 0, 0);
      ready = 4'b1110;
      apply("R2");

      // R5/R7: several slots blocked on different units, top unit 6.
      set_slot(0, 1, 0, 8'h41); set_slot(1, 2, 0, 8'h0c);
      set_slot(2, 3, 0, 8'h10); set_slot(3, 4, 0, 8'h20);
      ready = 4'b1111; free = 8'h31;
      apply("R5");

      // R5: the next cycle with no pressure reports an empty mask.
      free = 8'hff;
      apply("R5");

      // R4: every ready slot blocked, so no grant.
      free = 8'h00;
      apply("R4");

      // Sweep over mixed patterns with frequent rank ties.
      for (int v = 0; v < 6000; v++) begin
         ready = N'($urandom);
         src   = (N*IW)'($urandom);
         users = (N*UW)'($urandom);
         req   = (N*RW)'($urandom & $urandom & $urandom);
         free  = RW'($urandom | $urandom);
         if (v % 7 == 0) free = RW'($urandom);
         apply("");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule